// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Unit

This block is the per-processor side of an interrupt controller that handles acknowledge and end-of-interrupt (EOI) traffic. Another block picks the highest-priority pending source and presents its ID and priority. When the processor acknowledges, this unit decides whether that source may preempt the interrupt now in service. If it may, the unit makes it the running interrupt and asks for its pending bit to be cleared. If it may not, the unit returns the spurious ID 1023.

Every interrupt that is taken remembers which interrupt it preempted. These links form a chain, and the chain lets nested handlers unwind in the right order. An EOI for the running interrupt pops it, and the interrupt it preempted becomes the running one again. An EOI for an interrupt deeper in the chain removes that interrupt from the chain. A small walker finds it by following one link per clock cycle, and it raises `busy` while it does so. When a completed source is level-sensitive, still enabled and its line is still high, the unit asks for its pending bit to be set again.

Top module: `irq_ack_unit`

## Requirements
- R1: On an accepted acknowledge, the unit returns ID 1023 in any of these cases: `hp_id` is 1023, `hp_id` is not below `NUM_SRC`, or the zero-extended `hp_prio` is not strictly below `run_prio`. In these cases `run_id`, `run_prio` and the chain are unchanged and `pend_clr` stays low.
- R2: In every other case of an accepted acknowledge, one cycle later `ack_valid` pulses with `ack_id = hp_id`. In the same cycle `pend_clr` pulses with `pend_clr_id = hp_id`, `run_id` becomes `hp_id` and `run_prio` becomes `hp_prio`. The previous running ID is stored as the new interrupt's link.
- R3: After reset, and whenever `run_id` is 1023, `run_prio` is 9'h100. After reset `busy`, `ack_valid`, `pend_clr` and `pend_set` are low.
- R4: The EOI ID is `eoi_wdata[9:0]`, and the upper bits are ignored. An EOI whose ID is not below `NUM_SRC` has no effect; 1023 is such an ID.
- R5: An EOI arriving while `run_id` is 1023 has no effect.
- R6: An effective EOI of a source that is enabled (`src_enable` = 1), level-sensitive (`src_edge` = 0) and has its line high (`src_level` = 1) pulses `pend_set` with that ID one cycle later. Any other EOI leaves `pend_set` low.
- R7: An EOI whose ID equals `run_id` completes in one cycle. `run_id` becomes the popped interrupt's link. `run_prio` becomes the priority in `src_prio` of the new running ID, or 9'h100 if that ID is 1023.
- R8: An effective EOI of any other ID raises `busy` from the next cycle. The walker starts at `run_id` and examines one link per cycle. When it reaches the entry whose link is the EOI ID, it replaces that link with the EOI ID's own link. `run_id` and `run_prio` do not change during the walk.
- R9: A walk that reaches link 1023 without finding the EOI ID ends with the chain unchanged and `busy` low.
- R10: While `busy` is high, `ack_req` and `eoi_req` are ignored: no `ack_valid` pulse and no state change.
- R11: When `ack_req` and `eoi_req` arrive together while not busy, the acknowledge is served and the EOI is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hp_id | input | 10 | Highest-pending source ID, 1023 for none |
| hp_prio | input | PRIO_W | Priority of `hp_id` (lower is more urgent) |
| src_prio | input | NUM_SRC*PRIO_W | Priority of each source, source i at bits [i*PRIO_W +: PRIO_W] |
| src_enable | input | NUM_SRC | Per-source enable |
| src_level | input | NUM_SRC | Per-source line level |
| src_edge | input | NUM_SRC | Per-source trigger: 1 edge, 0 level |
| ack_req | input | 1 | Acknowledge request strobe |
| eoi_req | input | 1 | End-of-interrupt strobe |
| eoi_wdata | input | DATA_W | EOI write value, ID in bits [9:0] |
| ack_valid | output | 1 | Acknowledge result valid pulse |
| ack_id | output | 10 | Acknowledged ID or 1023 |
| run_id | output | 10 | Running interrupt ID, 1023 for none |
| run_prio | output | PRIO_W+1 | Running priority, 9'h100 when idle |
| busy | output | 1 | Chain walk in progress |
| pend_clr | output | 1 | Request to clear a pending bit |
| pend_clr_id | output | 10 | ID whose pending bit is to be cleared |
| pend_set | output | 1 | Request to set a pending bit |
| pend_set_id | output | 10 | ID whose pending bit is to be set |

## Verification
The hardest state to reach is a preemption chain several levels deep, followed by an EOI for an interrupt in the middle of that chain. An acknowledge only succeeds when the priority strictly drops, so the stimulus has to acknowledge sources in falling priority order. A directed sequence does this: it builds a four-deep chain, removes a middle member, and probes the walk with an acknowledge that `busy` must reject. It then walks the whole chain for an ID that is not in it and unwinds the rest by pops. After that, random traffic runs with fixed per-source priorities, so every chain stays strictly ordered. In that traffic, half of the EOIs name the running ID and the rest name random or out-of-range IDs.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  localparam int unsigned ID_W = 10;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

  typedef enum logic [0:0] {
    WS_IDLE = 1'b0,
    WS_WALK = 1'b1
  } walk_state_e;
endpackage

// File: rtl/irq_link_table.sv
module irq_link_table
  import irq_ack_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [ID_W-1:0] wr_addr,
  input  logic [ID_W-1:0] wr_data,
  input  logic [ID_W-1:0] rd_addr_a,
  output logic [ID_W-1:0] rd_data_a,
  input  logic [ID_W-1:0] rd_addr_b,
  output logic [ID_W-1:0] rd_data_b
);
  localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [ID_W-1:0] SRC_CNT = ID_W'(NUM_SRC);

  logic [ID_W-1:0] ent [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_ent
    logic            hit;
    logic [ID_W-1:0] link_q;
    assign hit = wr_en && (wr_addr == ID_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        link_q <= SPURIOUS_ID;
      end else if (hit) begin
        link_q <= wr_data;
      end
    end
    assign ent[g] = link_q;
  end

  assign rd_data_a = (rd_addr_a < SRC_CNT) ? ent[rd_addr_a[IDX_W-1:0]] : SPURIOUS_ID;
  assign rd_data_b = (rd_addr_b < SRC_CNT) ? ent[rd_addr_b[IDX_W-1:0]] : SPURIOUS_ID;

  AST_LINK_WR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_addr < SRC_CNT) else $error("link write out of range"); // R2
  AST_LINK_WR_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_data < SRC_CNT || wr_data == SPURIOUS_ID)) else $error("bad link value"); // R8
endmodule

// File: rtl/irq_chain_walk.sv
module irq_chain_walk
  import irq_ack_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [ID_W-1:0] start_cursor,
  input  logic [ID_W-1:0] start_target,
  input  logic [ID_W-1:0] link_cur,
  output logic            busy,
  output logic [ID_W-1:0] cursor,
  output logic [ID_W-1:0] target,
  output logic            splice_we
);
  localparam int unsigned CNT_W = $clog2(NUM_SRC + 1);
  localparam logic [CNT_W-1:0] STEP_LIM = CNT_W'(NUM_SRC - 1);

  walk_state_e     st_q, st_d;
  logic [ID_W-1:0] cur_q, cur_d, tgt_q, tgt_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d      = st_q;
    cur_d     = cur_q;
    tgt_d     = tgt_q;
    cnt_d     = cnt_q;
    splice_we = 1'b0;
    unique case (st_q)
      WS_IDLE: begin
        if (start) begin
          st_d  = WS_WALK;
          cur_d = start_cursor;
          tgt_d = start_target;
          cnt_d = '0;
        end
      end
      WS_WALK: begin
        if (link_cur == SPURIOUS_ID) begin
          st_d = WS_IDLE;
        end else if (link_cur == tgt_q) begin
          splice_we = 1'b1;
          st_d      = WS_IDLE;
        end else if (cnt_q == STEP_LIM) begin
          st_d = WS_IDLE;
        end else begin
          cur_d = link_cur;
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= WS_IDLE;
      cur_q <= SPURIOUS_ID;
      tgt_q <= SPURIOUS_ID;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cur_q <= cur_d;
      tgt_q <= tgt_d;
      cnt_q <= cnt_d;
    end
  end

  assign busy   = (st_q == WS_WALK);
  assign cursor = cur_q;
  assign target = tgt_q;

  AST_WALK_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt_q <= STEP_LIM) else $error("walk ran past chain length"); // R9
  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy) else $error("walk started while busy"); // R10
  AST_SPLICE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    splice_we |=> !busy) else $error("walk continued after splice"); // R8
endmodule

// File: rtl/irq_ack_unit.sv
module irq_ack_unit
  import irq_ack_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned PRIO_W  = 8,
  parameter int unsigned DATA_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ID_W-1:0]           hp_id,
  input  logic [PRIO_W-1:0]         hp_prio,
  input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
  input  logic [NUM_SRC-1:0]        src_enable,
  input  logic [NUM_SRC-1:0]        src_level,
  input  logic [NUM_SRC-1:0]        src_edge,
  input  logic                      ack_req,
  input  logic                      eoi_req,
  input  logic [DATA_W-1:0]         eoi_wdata,
  output logic                      ack_valid,
  output logic [ID_W-1:0]           ack_id,
  output logic [ID_W-1:0]           run_id,
  output logic [PRIO_W:0]           run_prio,
  output logic                      busy,
  output logic                      pend_clr,
  output logic [ID_W-1:0]           pend_clr_id,
  output logic                      pend_set,
  output logic [ID_W-1:0]           pend_set_id
);
  localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [ID_W-1:0] SRC_CNT = ID_W'(NUM_SRC);
  localparam logic [PRIO_W:0] IDLE_PRIO = {1'b1, {PRIO_W{1'b0}}};

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_l;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_l = rst_sync_q[1];

  logic [PRIO_W-1:0] prio_arr [NUM_SRC];
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_prio
    assign prio_arr[g] = src_prio[g*PRIO_W +: PRIO_W];
  end

  logic [ID_W-1:0]   run_id_q, run_id_d, ack_id_q, ack_id_d;
  logic [PRIO_W:0]   run_prio_q, run_prio_d;
  logic              ack_valid_q, pend_clr_q, pend_set_q;
  logic [ID_W-1:0]   pend_clr_id_q, pend_set_id_q;
  logic              walk_busy, walk_start, splice_we;
  logic [ID_W-1:0]   walk_cursor, walk_target;
  logic [ID_W-1:0]   link_rd_a, link_a, link_b;
  logic              link_we;
  logic [ID_W-1:0]   link_waddr, link_wdata;
  logic [ID_W-1:0]   eoi_id;
  logic [IDX_W-1:0]  eoi_idx, pop_idx;
  logic              ack_go, eoi_go, hp_ok, ack_take, eoi_ok, eoi_pop, repend;
  logic              unused_wdata;

  assign eoi_id       = eoi_wdata[ID_W-1:0];
  assign unused_wdata = ^eoi_wdata[DATA_W-1:ID_W];
  assign eoi_idx      = eoi_id[IDX_W-1:0];
  assign pop_idx      = link_a[IDX_W-1:0];

  assign ack_go   = ack_req && !walk_busy;
  assign eoi_go   = eoi_req && !walk_busy && !ack_req;
  assign hp_ok    = (hp_id < SRC_CNT) && ({1'b0, hp_prio} < run_prio_q);
  assign ack_take = ack_go && hp_ok;
  assign eoi_ok   = eoi_go && (eoi_id < SRC_CNT) && (run_id_q != SPURIOUS_ID);
  assign eoi_pop  = eoi_ok && (eoi_id == run_id_q);
  assign walk_start = eoi_ok && !eoi_pop;
  assign repend   = eoi_ok && !src_edge[eoi_idx] && src_enable[eoi_idx] && src_level[eoi_idx];

  assign link_rd_a  = walk_busy ? walk_cursor : run_id_q;
  assign link_we    = ack_take || splice_we;
  assign link_waddr = splice_we ? walk_cursor : hp_id;
  assign link_wdata = splice_we ? link_b : run_id_q;

  irq_link_table #(.NUM_SRC(NUM_SRC)) u_links (
    .clk       (clk),
    .rst_n     (rst_l),
    .wr_en     (link_we),
    .wr_addr   (link_waddr),
    .wr_data   (link_wdata),
    .rd_addr_a (link_rd_a),
    .rd_data_a (link_a),
    .rd_addr_b (walk_target),
    .rd_data_b (link_b)
  );

  irq_chain_walk #(.NUM_SRC(NUM_SRC)) u_walk (
    .clk          (clk),
    .rst_n        (rst_l),
    .start        (walk_start),
    .start_cursor (run_id_q),
    .start_target (eoi_id),
    .link_cur     (link_a),
    .busy         (walk_busy),
    .cursor       (walk_cursor),
    .target       (walk_target),
    .splice_we    (splice_we)
  );

  always_comb begin
    run_id_d   = run_id_q;
    run_prio_d = run_prio_q;
    ack_id_d   = ack_id_q;
    if (ack_go) begin
      ack_id_d = hp_ok ? hp_id : SPURIOUS_ID;
    end
    if (ack_take) begin
      run_id_d   = hp_id;
      run_prio_d = {1'b0, hp_prio};
    end else if (eoi_pop) begin
      run_id_d   = link_a;
      run_prio_d = (link_a == SPURIOUS_ID) ? IDLE_PRIO : {1'b0, prio_arr[pop_idx]};
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      run_id_q      <= SPURIOUS_ID;
      run_prio_q    <= IDLE_PRIO;
      ack_valid_q   <= 1'b0;
      ack_id_q      <= SPURIOUS_ID;
      pend_clr_q    <= 1'b0;
      pend_clr_id_q <= SPURIOUS_ID;
      pend_set_q    <= 1'b0;
      pend_set_id_q <= SPURIOUS_ID;
    end else begin
      run_id_q    <= run_id_d;
      run_prio_q  <= run_prio_d;
      ack_valid_q <= ack_go;
      ack_id_q    <= ack_id_d;
      pend_clr_q  <= ack_take;
      pend_set_q  <= repend;
      if (ack_take) pend_clr_id_q <= hp_id;
      if (repend)   pend_set_id_q <= eoi_id;
    end
  end

  assign ack_valid   = ack_valid_q;
  assign ack_id      = ack_id_q;
  assign run_id      = run_id_q;
  assign run_prio    = run_prio_q;
  assign busy        = walk_busy;
  assign pend_clr    = pend_clr_q;
  assign pend_clr_id = pend_clr_id_q;
  assign pend_set    = pend_set_q;
  assign pend_set_id = pend_set_id_q;

  AST_SPURIOUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_l)
    ack_valid_q && ack_id_q == SPURIOUS_ID |-> run_id_q == $past(run_id_q) && run_prio_q == $past(run_prio_q) && !pend_clr_q)
    else $error("spurious ack changed state"); // R1
  AST_ACK_RUNS: assert property (@(posedge clk) disable iff (!rst_l)
    ack_valid_q && ack_id_q != SPURIOUS_ID |-> run_id_q == ack_id_q && pend_clr_q && pend_clr_id_q == ack_id_q)
    else $error("ack did not install running ID"); // R2
  AST_ACK_PRIO_DROP: assert property (@(posedge clk) disable iff (!rst_l)
    ack_valid_q && ack_id_q != SPURIOUS_ID |-> run_prio_q < $past(run_prio_q))
    else $error("ack without priority drop"); // R2
  AST_IDLE_PRIO: assert property (@(posedge clk) disable iff (!rst_l)
    run_id_q == SPURIOUS_ID |-> run_prio_q == IDLE_PRIO) else $error("idle priority wrong"); // R3
  AST_EOI_RANGE: assert property (@(posedge clk) disable iff (!rst_l)
    !walk_busy && eoi_req && !ack_req && eoi_id >= SRC_CNT |=> !pend_set_q && !walk_busy && $stable(run_id_q))
    else $error("out-of-range EOI acted"); // R4
  AST_EOI_IDLE_NOP: assert property (@(posedge clk) disable iff (!rst_l)
    !walk_busy && eoi_req && !ack_req && run_id_q == SPURIOUS_ID |=> run_id_q == SPURIOUS_ID && !walk_busy && !pend_set_q)
    else $error("EOI with nothing running acted"); // R5
  AST_WALK_RUN_STABLE: assert property (@(posedge clk) disable iff (!rst_l)
    walk_busy |=> $stable(run_id_q) && $stable(run_prio_q)) else $error("running state moved during walk"); // R8
  AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_l)
    walk_busy |=> !ack_valid_q && !pend_set_q) else $error("request served while busy"); // R10
  AST_DUAL_REQ: assert property (@(posedge clk) disable iff (!rst_l)
    !walk_busy && ack_req && eoi_req |=> ack_valid_q && !pend_set_q && !walk_busy)
    else $error("dual request not resolved to ack"); // R11
endmodule

// File: tb/irq_ack_unit_tb.sv
`timescale 1ns/1ps
module irq_ack_unit_tb;
  localparam int SRC = 16;
  localparam int PW  = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [9:0]      hp_id;
  logic [PW-1:0]   hp_prio;
  logic [SRC*PW-1:0] src_prio;
  logic [SRC-1:0]  src_enable, src_level, src_edge;
  logic            ack_req, eoi_req;
  logic [31:0]     eoi_wdata;
  logic            ack_valid, busy, pend_clr, pend_set;
  logic [9:0]      ack_id, run_id, pend_clr_id, pend_set_id;
  logic [PW:0]     run_prio;

  always #5 clk = ~clk;

  irq_ack_unit #(.NUM_SRC(SRC), .PRIO_W(PW), .DATA_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .hp_id(hp_id), .hp_prio(hp_prio), .src_prio(src_prio),
    .src_enable(src_enable), .src_level(src_level), .src_edge(src_edge),
    .ack_req(ack_req), .eoi_req(eoi_req), .eoi_wdata(eoi_wdata),
    .ack_valid(ack_valid), .ack_id(ack_id), .run_id(run_id), .run_prio(run_prio),
    .busy(busy), .pend_clr(pend_clr), .pend_clr_id(pend_clr_id),
    .pend_set(pend_set), .pend_set_id(pend_set_id)
  );

  logic [PW-1:0] bprio [SRC];
  always_comb for (int i = 0; i < SRC; i++) src_prio[i*PW +: PW] = bprio[i];

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference model state
  logic [9:0] m_link [SRC];
  logic [9:0] m_run, m_cur, m_tgt;
  logic [PW:0] m_prio;
  bit m_busy;
  bit e_ack_v, e_clr, e_set;
  logic [9:0] e_ack_id, e_clr_id, e_set_id;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    logic [9:0] nxt, id;
    e_ack_v = 0; e_clr = 0; e_set = 0;
    if (m_busy) begin
      nxt = m_link[m_cur[3:0]];
      if (nxt == 10'd1023) m_busy = 0;
      else if (nxt == m_tgt) begin m_link[m_cur[3:0]] = m_link[m_tgt[3:0]]; m_busy = 0; end
      else m_cur = nxt;
    end else if (ack_req) begin
      e_ack_v = 1;
      if (hp_id >= 10'(SRC) || {1'b0, hp_prio} >= m_prio) e_ack_id = 10'd1023;
      else begin
        e_ack_id = hp_id; e_clr = 1; e_clr_id = hp_id;
        m_link[hp_id[3:0]] = m_run; m_run = hp_id; m_prio = {1'b0, hp_prio};
      end
    end else if (eoi_req) begin
      id = eoi_wdata[9:0];
      if (id < 10'(SRC) && m_run != 10'd1023) begin
        if (!src_edge[id[3:0]] && src_enable[id[3:0]] && src_level[id[3:0]]) begin
          e_set = 1; e_set_id = id;
        end
        if (id == m_run) begin
          m_run  = m_link[m_run[3:0]];
          m_prio = (m_run == 10'd1023) ? 9'h100 : {1'b0, bprio[m_run[3:0]]};
        end else begin
          m_busy = 1; m_cur = m_run; m_tgt = id;
        end
      end
    end
  endtask

  task automatic step(input string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk(tag, "ack_valid", 32'(ack_valid), 32'(e_ack_v));
    if (e_ack_v) chk(tag, "ack_id", 32'(ack_id), 32'(e_ack_id));
    chk(tag, "run_id", 32'(run_id), 32'(m_run));
    chk(tag, "run_prio", 32'(run_prio), 32'(m_prio));
    chk(tag, "busy", 32'(busy), 32'(m_busy));
    chk(tag, "pend_clr", 32'(pend_clr), 32'(e_clr));
    if (e_clr) chk(tag, "pend_clr_id", 32'(pend_clr_id), 32'(e_clr_id));
    chk(tag, "pend_set", 32'(pend_set), 32'(e_set));
    if (e_set) chk(tag, "pend_set_id", 32'(pend_set_id), 32'(e_set_id));
  endtask

  task automatic do_ack(input logic [9:0] id, input string tag);
    hp_id = id;
    hp_prio = (id < 10'(SRC)) ? bprio[id[3:0]] : 8'h00;
    ack_req = 1'b1;
    step(tag);
    ack_req = 1'b0;
  endtask

  task automatic do_eoi(input logic [31:0] wd, input string tag);
    eoi_wdata = wd;
    eoi_req = 1'b1;
    step(tag);
    eoi_req = 1'b0;
  endtask

  task automatic drain(input string tag);
    while (m_busy) step(tag);
  endtask

  initial begin
    #500us;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < SRC; i++) begin bprio[i] = 8'($urandom % 64); m_link[i] = 10'd1023; end
    bprio[1] = 8'd40; bprio[2] = 8'd30; bprio[3] = 8'd20; bprio[4] = 8'd10;
    bprio[5] = 8'd50; bprio[6] = 8'd5;
    m_run = 10'd1023; m_prio = 9'h100; m_busy = 0; m_cur = '0; m_tgt = '0;
    rst_n = 1'b0; hp_id = 10'd1023; hp_prio = '0; ack_req = 0; eoi_req = 0; eoi_wdata = '0;
    src_enable = '1; src_level = '0; src_edge = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3: reset state
    chk("R3", "run_id", 32'(run_id), 32'd1023);
    chk("R3", "run_prio", 32'(run_prio), 32'h100);
    chk("R3", "busy", 32'(busy), 32'd0);
    chk("R3", "ack_valid", 32'(ack_valid), 32'd0);

    // R5: EOI with nothing running, even for a raised level source
    src_level = 16'h0004;
    do_eoi(32'h0000_0002, "R5");
    src_level = '0;
    // R1: spurious acknowledges
    do_ack(10'd1023, "R1");
    do_ack(10'd20, "R1");
    // R2: build nesting 1 -> 2 -> 3 -> 4
    do_ack(10'd1, "R2");
    do_ack(10'd5, "R1");
    do_ack(10'd2, "R2");
    do_ack(10'd3, "R2");
    do_ack(10'd4, "R2");
    // R11: simultaneous ack and eoi
    eoi_wdata = 32'd4; eoi_req = 1'b1;
    do_ack(10'd6, "R11");
    eoi_req = 1'b0;
    // R4: out of range IDs ignored, upper bits of wdata ignored
    do_eoi(32'hFFFF_FC14, "R4");
    do_eoi(32'h0000_03FF, "R4");
    // R8: remove ID 2 from the middle (upper bits set), probe busy with an ack (R10)
    do_eoi(32'h1234_5C02, "R8");
    do_ack(10'd6, "R10");
    drain("R8");
    chk("R8", "run_id after splice", 32'(run_id), 32'd6);
    // R9: ID not in chain
    do_eoi(32'd9, "R9");
    eoi_wdata = 32'd6; eoi_req = 1'b1;
    step("R10");
    eoi_req = 1'b0;
    drain("R9");
    // R7 / R6: unwind by pops
    do_eoi(32'd6, "R7");
    do_eoi(32'd4, "R7");
    src_level = 16'h0008;
    do_eoi(32'd3, "R6");
    src_level = '0;
    do_eoi(32'd1, "R7");
    chk("R3", "run_id idle", 32'(run_id), 32'd1023);
    chk("R3", "run_prio idle", 32'(run_prio), 32'h100);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [9:0] id;
      src_enable = 16'($urandom);
      src_level  = 16'($urandom);
      src_edge   = 16'($urandom);
      r = int'($urandom % 10);
      if (r == 0) id = 10'd1023;
      else if (r == 1) id = 10'(16 + $urandom % 40);
      else id = 10'($urandom % SRC);
      hp_id = id;
      hp_prio = (id < 10'(SRC)) ? bprio[id[3:0]] : 8'($urandom);
      ack_req = ($urandom % 100) < 35;
      eoi_req = ($urandom % 100) < 35;
      r = int'($urandom % 10);
      if (r < 5) id = m_run;
      else if (r < 8) id = 10'($urandom % SRC);
      else id = 10'($urandom);
      eoi_wdata = {22'($urandom), id};
      step("random");
    end
    ack_req = 0; eoi_req = 0;
    drain("random");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule